// File: doc/BRIEF.md
# IF Variable-Gain-Amplifier Control-Voltage Loop Controller

This block carries out one closed-loop correction of the control word that sets the voltage on a two-stage intermediate-frequency variable-gain amplifier. After a start pulse it takes 16 detector samples from an ADC stream and averages them. In constant-envelope mode the samples are taken back to back. Otherwise a programmable number of idle cycles separates them, about 334 cycles at 50 MHz for a 6.68 µs interval. The average is then classed against a trusted detector window. Inside the window, a closed-form linear correction moves the control word to the point where the output reaches the −19 dBm target (1.625 V at the detector). Below the window the word is raised by a fixed coarse step, and above it the word is lowered by that step. The result is clamped and offered as a 12-bit DAC code.

The fixed-point scale assumes an ADC step of 3.125 mV, so 0.375 V is code 120, 2.75 V is code 880 and 1.625 V is code 520. It also assumes a DAC step of 0.5 mV. The detector slope is 0.05 V/dB and each of the two stages has a gain slope of 50 dB/V. A control-voltage change of (target − measured power)/100 V therefore becomes 1.25 DAC codes per ADC code of error below the aim point.

Both data interfaces use valid/ready. A sample moves only in a cycle where `smp_valid` and `smp_ready` are both high. The block drives `smp_ready` high only while it is collecting and no spacing interval is running, so a source can hold data indefinitely. On the output, `dac_valid` stays high with `dac_code` unchanged until the consumer raises `dac_ready`. Back-pressure on the output therefore stalls the block, and no correction is lost. The next correction starts from the word last emitted.

Top module: `ifvga_loop_ctrl`

## Requirements
- R1: During and after reset, `dac_valid`, `smp_ready` and `busy` are low and `dac_code` equals `init_word`, which becomes the starting control word.
- R2: A `start` pulse begins a correction only while `busy` is low. A `start` in any other cycle, including the output handshake cycle, has no effect, and `busy` and `smp_ready` stay low afterwards.
- R3: A correction accepts exactly 16 samples on the valid/ready stream. Its mean is the floor of their sum divided by 16.
- R4: With `const_env`=1, samples are accepted in consecutive cycles. With `const_env`=0, `smp_ready` stays low for `gap_cycles` cycles after each accepted sample except the last.
- R5: For a mean from 120 to 880 inclusive, the new word is cur + floor(5·(520 − mean)/4), using arithmetic floor for negative values.
- R6: For a mean below 120, the new word is cur + 256.
- R7: For a mean above 880, the new word is cur − 256.
- R8: Every emitted word is clamped into the range from 100 to 4000 inclusive.
- R9: `dac_valid` stays high with a stable `dac_code` until `dac_ready`. After the handshake the block is idle, and the emitted word is the base for the next correction.
- R10: Outside a collection `smp_ready` is low, so samples offered then are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_word | input | 12 | Control word loaded during reset |
| start | input | 1 | Pulse that begins one correction |
| const_env | input | 1 | 1 = constant envelope, samples back to back |
| gap_cycles | input | 16 | Idle cycles between samples when const_env is 0 |
| smp_valid | input | 1 | Detector sample offered |
| smp_ready | output | 1 | Block takes the offered sample |
| smp_data | input | 10 | Detector ADC code |
| dac_valid | output | 1 | New control word offered |
| dac_ready | input | 1 | Consumer takes the control word |
| dac_code | output | 12 | Control word for the DAC |
| busy | output | 1 | A correction is in progress |

## Verification
Two events can fall in the same cycle: the output handshake that ends one correction and a `start` pulse that would begin the next. The bench raises `start` together with `dac_ready` on the cycle it releases the output word. It then judges, one cycle later, that `busy` and `smp_ready` are low and that a fresh correction still begins from the emitted word. Random corrections with random sample values, envelope modes, spacings and output stall lengths are mixed with directed means at 119, 120, 880 and 881 and with clamp cases at both ends.

// File: rtl/ifvga_pkg.sv
package ifvga_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_CALC    = 2'd2,
    ST_EMIT    = 2'd3
  } ifvga_state_e;

  typedef enum logic [1:0] {
    Z_LINEAR = 2'd0,
    Z_RAISE  = 2'd1,
    Z_LOWER  = 2'd2
  } ifvga_zone_e;
endpackage

// File: rtl/ifvga_sampler.sv
module ifvga_sampler #(
  parameter int ADC_W      = 10,
  parameter int NSAMP_LOG2 = 4,
  parameter int GAP_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             const_env,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic             smp_valid,
  input  logic [ADC_W-1:0] smp_data,
  output logic             smp_ready,
  output logic             done,
  output logic [ADC_W-1:0] mean
);
  localparam int NSAMP = 1 << NSAMP_LOG2;
  localparam int CNT_W = NSAMP_LOG2 + 1;
  localparam int SUM_W = ADC_W + NSAMP_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic [GAP_W-1:0] gap_q;
  logic             accept;
  logic             last;

  assign smp_ready = en && (cnt_q != CNT_W'(NSAMP)) && (gap_q == '0);
  assign accept    = smp_valid && smp_ready;
  assign last      = (cnt_q == CNT_W'(NSAMP - 1));
  assign done      = (cnt_q == CNT_W'(NSAMP));
  assign mean      = sum_q[SUM_W-1:NSAMP_LOG2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
      gap_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      sum_q <= '0;
      gap_q <= '0;
    end else if (accept) begin
      sum_q <= sum_q + {{NSAMP_LOG2{1'b0}}, smp_data};
      cnt_q <= cnt_q + 1'b1;
      gap_q <= (!const_env && !last) ? gap_cycles : '0;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !const_env && (gap_cycles != '0) && !last |=> !smp_ready); // R4
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && const_env && !last && en |=> smp_ready || !en); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NSAMP)); // R3
endmodule

// File: rtl/ifvga_law.sv
module ifvga_law
  import ifvga_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int DAC_W       = 12,
  parameter int LO_CODE     = 120,
  parameter int HI_CODE     = 880,
  parameter int AIM_CODE    = 520,
  parameter int GAIN_NUM    = 5,
  parameter int GAIN_SHIFT  = 2,
  parameter int COARSE_STEP = 256,
  parameter int VG_MIN      = 100,
  parameter int VG_MAX      = 4000
) (
  input  logic [ADC_W-1:0] mean,
  input  logic [DAC_W-1:0] cur,
  output logic [DAC_W-1:0] nxt,
  output ifvga_zone_e      zone
);
  localparam int CW = DAC_W + ADC_W + 6;

  logic signed [CW-1:0] diff;
  logic signed [CW-1:0] scaled;
  logic signed [CW-1:0] cur_s;
  logic signed [CW-1:0] cand;
  logic signed [CW-1:0] lim_lo;
  logic signed [CW-1:0] lim_hi;

  always_comb begin
    if (mean < ADC_W'(LO_CODE))      zone = Z_RAISE;
    else if (mean > ADC_W'(HI_CODE)) zone = Z_LOWER;
    else                             zone = Z_LINEAR;
  end

  always_comb begin
    lim_lo = $signed(CW'(VG_MIN));
    lim_hi = $signed(CW'(VG_MAX));
    cur_s  = $signed({{(CW-DAC_W){1'b0}}, cur});
    diff   = $signed(CW'(AIM_CODE)) - $signed({{(CW-ADC_W){1'b0}}, mean});
    scaled = (diff * $signed(CW'(GAIN_NUM))) >>> GAIN_SHIFT;
    case (zone)
      Z_RAISE: cand = cur_s + $signed(CW'(COARSE_STEP));
      Z_LOWER: cand = cur_s - $signed(CW'(COARSE_STEP));
      default: cand = cur_s + scaled;
    endcase
    if (cand < lim_lo)      nxt = DAC_W'(VG_MIN);
    else if (cand > lim_hi) nxt = DAC_W'(VG_MAX);
    else                    nxt = cand[DAC_W-1:0];
  end
endmodule

// File: rtl/ifvga_loop_ctrl.sv
module ifvga_loop_ctrl
  import ifvga_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int DAC_W       = 12,
  parameter int NSAMP_LOG2  = 4,
  parameter int GAP_W       = 16,
  parameter int LO_CODE     = 120,
  parameter int HI_CODE     = 880,
  parameter int AIM_CODE    = 520,
  parameter int GAIN_NUM    = 5,
  parameter int GAIN_SHIFT  = 2,
  parameter int COARSE_STEP = 256,
  parameter int VG_MIN      = 100,
  parameter int VG_MAX      = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DAC_W-1:0] init_word,
  input  logic             start,
  input  logic             const_env,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [ADC_W-1:0] smp_data,
  output logic             dac_valid,
  input  logic             dac_ready,
  output logic [DAC_W-1:0] dac_code,
  output logic             busy
);
  ifvga_state_e     state_q, state_d;
  logic [DAC_W-1:0] vg_q;
  logic [DAC_W-1:0] vg_nxt;
  logic [ADC_W-1:0] mean;
  logic             coll_done;
  logic             clr;
  ifvga_zone_e      zone;

  assign clr = (state_q == ST_IDLE) && start;

  ifvga_sampler #(
    .ADC_W(ADC_W), .NSAMP_LOG2(NSAMP_LOG2), .GAP_W(GAP_W)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(state_q == ST_COLLECT),
    .const_env(const_env), .gap_cycles(gap_cycles),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .done(coll_done), .mean(mean)
  );

  ifvga_law #(
    .ADC_W(ADC_W), .DAC_W(DAC_W), .LO_CODE(LO_CODE), .HI_CODE(HI_CODE),
    .AIM_CODE(AIM_CODE), .GAIN_NUM(GAIN_NUM), .GAIN_SHIFT(GAIN_SHIFT),
    .COARSE_STEP(COARSE_STEP), .VG_MIN(VG_MIN), .VG_MAX(VG_MAX)
  ) u_law (
    .mean(mean), .cur(vg_q), .nxt(vg_nxt), .zone(zone)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start)     state_d = ST_COLLECT;
      ST_COLLECT: if (coll_done) state_d = ST_CALC;
      ST_CALC:                   state_d = ST_EMIT;
      ST_EMIT:    if (dac_ready) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vg_q    <= init_word;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CALC) vg_q <= vg_nxt;
    end
  end

  assign dac_valid = (state_q == ST_EMIT);
  assign dac_code  = vg_q;
  assign busy      = (state_q != ST_IDLE);

  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_COLLECT) |-> !smp_ready); // R10
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && !dac_ready |=> dac_valid && $stable(dac_code)); // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> (dac_code >= DAC_W'(VG_MIN)) && (dac_code <= DAC_W'(VG_MAX))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && dac_ready && start |=> !busy); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALC) && (zone == Z_RAISE) && (vg_q <= DAC_W'(VG_MAX - COARSE_STEP))
      && (vg_q >= DAC_W'(VG_MIN)) |=> dac_code == $past(dac_code) + DAC_W'(COARSE_STEP)); // R6
endmodule

// File: tb/ifvga_loop_ctrl_tb.sv
module ifvga_loop_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] init_word = 12'd2048;
  logic        start = 1'b0;
  logic        const_env = 1'b1;
  logic [15:0] gap_cycles = 16'd0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [9:0]  smp_data = '0;
  logic        dac_valid;
  logic        dac_ready = 1'b0;
  logic [11:0] dac_code;
  logic        busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int cur = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ifvga_loop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .init_word(init_word), .start(start),
    .const_env(const_env), .gap_cycles(gap_cycles), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .dac_valid(dac_valid),
    .dac_ready(dac_ready), .dac_code(dac_code), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_next(input int c, input int m);
    int n;
    if (m < 120)      n = c + 256;           // R6
    else if (m > 880) n = c - 256;           // R7
    else              n = c + (((520 - m) * 5) >>> 2); // R5
    if (n < 100)  n = 100;                   // R8
    if (n > 4000) n = 4000;
    return n;
  endfunction

  task automatic do_reset(input int iw);
    @(negedge clk);
    rst_n = 1'b0; init_word = 12'(iw);
    repeat (2) @(negedge clk);
    check("R1 dac_valid", int'(dac_valid), 0);
    check("R1 smp_ready", int'(smp_ready), 0);
    check("R1 dac_code", int'(dac_code), iw);
    rst_n = 1'b1;
    cur = iw;
  endtask

  // one correction; samples[i] given; stall = output hold cycles; clash = start with handshake
  task automatic correct(input bit ce, input int gap, input int s[16], input int stall, input bit clash);
    int sum = 0; int last_t = 0; int expv;
    const_env = ce; gap_cycles = 16'(gap);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      smp_valid = 1'b1; smp_data = 10'(s[i]);
      while (!smp_ready) @(negedge clk);
      if (i > 0 && (i == 1 || i == 8))
        check("R4 sample spacing", cyc - last_t, ce ? 1 : gap + 1);
      last_t = cyc; sum += s[i];
      @(negedge clk);
    end
    smp_valid = 1'b0;
    while (!dac_valid) @(negedge clk);
    expv = model_next(cur, sum / 16);
    check("R3/R5-R8 dac_code", int'(dac_code), expv);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R9 hold valid", int'(dac_valid), 1);
      check("R9 hold code", int'(dac_code), expv);
    end
    dac_ready = 1'b1; start = clash;
    @(negedge clk);
    dac_ready = 1'b0; start = 1'b0;
    check("R9 idle after handshake", int'(busy), 0);
    if (clash) begin
      check("R2 start ignored busy", int'(busy), 0);
      @(negedge clk);
      check("R2 start ignored ready", int'(smp_ready), 0);
    end
    cur = expv;
  endtask

  task automatic flat(input bit ce, input int gap, input int v, input int stall, input bit clash);
    int s[16];
    for (int i = 0; i < 16; i++) s[i] = v;
    correct(ce, gap, s, stall, clash);
  endtask

  initial begin
    int s[16];
    void'($urandom(32'd20240611));
    do_reset(2048);
    // R10: offered samples while idle are not taken
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 10'd1000;
    repeat (3) @(negedge clk);
    check("R10 idle ready low", int'(smp_ready), 0);
    smp_valid = 1'b0;
    flat(1'b1, 0, 520, 0, 1'b0);           // R1: init word kept at aim
    flat(1'b1, 0, 120, 2, 1'b0);           // R5 lower edge
    flat(1'b0, 3, 880, 1, 1'b1);           // R5 upper edge, R2 clash
    flat(1'b1, 0, 119, 0, 1'b0);           // R6
    flat(1'b0, 5, 881, 3, 1'b0);           // R7
    // R3: mean floor with uneven samples
    for (int i = 0; i < 16; i++) s[i] = (i < 15) ? 500 : 515;
    correct(1'b1, 0, s, 0, 1'b0);
    // R8 clamp high and low
    do_reset(3900);
    flat(1'b1, 0, 0, 0, 1'b0);
    flat(1'b1, 0, 120, 0, 1'b0);
    do_reset(150);
    flat(1'b0, 2, 1000, 0, 1'b0);
    flat(1'b1, 0, 880, 0, 1'b1);
    // constrained random
    do_reset(2048);
    for (int n = 0; n < 40; n++) begin
      int base = $urandom_range(1023, 0);
      for (int i = 0; i < 16; i++) begin
        int v = base + $urandom_range(60, 0) - 30;
        s[i] = (v < 0) ? 0 : ((v > 1023) ? 1023 : v);
      end
      correct(1'($urandom_range(1, 0)), $urandom_range(6, 0), s,
              $urandom_range(3, 0), 1'($urandom_range(1, 0)));
    end
    // long spacing as for a non-constant envelope at 50 MHz
    flat(1'b0, 334, 700, 0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule